// File: doc/BRIEF.md
# Masked Packed Double-to-Int64 Lane Controller

This block converts a vector of IEEE-754 double-precision values into signed 64-bit integers, one lane at a time, across a register of eight 64-bit lanes. Each operation gives a vector length of 128, 256 or 512 bits, which selects 2, 4 or 8 lanes. It also gives a per-lane writemask, which can be enabled or disabled, and a choice between merging and zeroing for lanes the mask turns off. A broadcast bit, for memory sources, makes every lane convert element 0. Two rounding fields are supplied, and a per-operation field can override the global one.

The block receives the previous destination vector and the source vector. It returns the new destination vector together with the invalid and inexact flags, OR-reduced over the lanes that were actually written. A reserved 4-bit specifier must hold all ones. When it does not, the operation is flagged undefined and the destination passes through unchanged. Results are registered and appear one cycle after the input strobe.

Top module: `dq_vec_convert`

## Requirements
- R1: `outValid` is high in exactly the cycle after each cycle in which `inValid` is high, and is low after reset.
- R2: The `vecLen` encoding is 0 for 2 lanes (128 bits), 1 for 4 lanes (256 bits), and 2 or 3 for 8 lanes (512 bits). Lane j occupies bits [64j+63:64j]. On a defined operation, every destination bit above the active length reads zero.
- R3: An active lane is written with its converted value when `maskEn` is low or when `mask[j]` is high.
- R4: With `zeroMode` low (merge), an active lane whose mask bit is clear keeps its `prevDest` value.
- R5: With `zeroMode` high, an active lane whose mask bit is clear reads zero.
- R6: When `bcastBit` and `srcIsMem` are both high, every written lane converts source lane 0.
- R7: The rounding mode is taken from `embRound` only when the length is 512, `srcIsMem` is low and `bcastBit` is high. In all other cases it is taken from `glbRound`. Rounding codes are 0 for nearest-even, 1 for toward minus infinity, 2 for toward plus infinity and 3 for toward zero.
- R8: A finite in-range input yields its integer rounded by the selected mode. The lane's inexact indication is set when any fraction was discarded.
- R9: A NaN, an infinity, or a value that rounds outside the signed 64-bit range yields 0x8000000000000000 and sets the lane's invalid indication. Exactly -2^63 converts without invalid.
- R10: `outInvalid` and `outInexact` are the OR of the lane indications over written lanes only. Masked lanes and lanes above the length never contribute.
- R11: When `regSpec` is not 4'b1111, `outUndef` is high, `outDest` equals `prevDest`, and both flags are low.
- R12: Reset clears `outValid`, `outDest`, the flags and `outUndef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| vecLen | input | 2 | Vector length code |
| maskEn | input | 1 | Writemask in force |
| mask | input | 8 | Per-lane writemask |
| zeroMode | input | 1 | 1 = zero masked lanes, 0 = merge |
| bcastBit | input | 1 | Broadcast / rounding-override bit |
| srcIsMem | input | 1 | Source comes from memory |
| embRound | input | 2 | Per-operation rounding code |
| glbRound | input | 2 | Global rounding code |
| regSpec | input | 4 | Reserved specifier, must be 4'b1111 |
| prevDest | input | 512 | Previous destination contents |
| srcVec | input | 512 | Source doubles |
| outValid | output | 1 | Result valid |
| outDest | output | 512 | New destination contents |
| outInvalid | output | 1 | OR of invalid over written lanes |
| outInexact | output | 1 | OR of inexact over written lanes |
| outUndef | output | 1 | Reserved specifier violated |

## Verification
The bench aims at rounding ties and negative fractions under all four modes. A design that got these wrong would return 3 for 2.5 under nearest-even, or -2 for -2.5 toward minus infinity. It also separates the two rounding sources, broadcast with a register source, and broadcast at 256 bits. A faulty design would round with the wrong field or copy lane 0 when it should not. Remaining cases are NaN lanes that are masked off or above the length, which a careless flag reduction would still report as invalid. The last is an illegal specifier, where a faulty design would overwrite or clear the destination.

// File: rtl/dq_vec_pkg.sv
package dq_vec_pkg;
  parameter int NUM_LANES = 8;
  parameter int LANE_W    = 64;
  localparam int VEC_W    = NUM_LANES * LANE_W;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_ZERO = 2'd3
  } roundMode_t;

  typedef struct packed {
    logic                 capture;
    logic                 undef;
    logic                 useBcast;
    roundMode_t           roundMode;
    logic [NUM_LANES-1:0] laneWrite;
    logic [NUM_LANES-1:0] laneZero;
  } laneStrobes_t;
endpackage

// File: rtl/dq_lane_convert.sv
module dq_lane_convert
  import dq_vec_pkg::*;
(
  input  logic [63:0] fpIn,
  input  roundMode_t  roundMode,
  output logic [63:0] intOut,
  output logic        invalid,
  output logic        inexact
);
  localparam int FRAC_W  = 52;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int EXT_W   = MANT_W + 64;
  localparam logic [10:0] UNITY_EXP = 11'd1075;
  localparam logic [10:0] TOP_EXP   = 11'd1086;

  logic              sgn;
  logic [10:0]       expo;
  logic [10:0]       effExp;
  logic [FRAC_W-1:0] frac;
  logic [MANT_W-1:0] mant;
  logic [EXT_W-1:0]  shifted;
  logic [MANT_W-1:0] intPart;
  logic [11:0]       rsh;
  logic              guard, sticky, roundUp;
  logic [63:0]       mag;

  always_comb begin
    sgn     = fpIn[63];
    expo    = fpIn[62:52];
    frac    = fpIn[FRAC_W-1:0];
    mant    = {expo != 11'd0, frac};
    effExp  = (expo == 11'd0) ? 11'd1 : expo;
    invalid = 1'b0;
    inexact = 1'b0;
    mag     = '0;
    shifted = '0;
    intPart = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    roundUp = 1'b0;
    rsh     = '0;
    if (expo == 11'h7FF) begin
      invalid = 1'b1;
    end else if (effExp >= UNITY_EXP) begin
      if (effExp >= TOP_EXP) begin
        invalid = !(sgn && effExp == TOP_EXP && frac == '0);
        mag     = 64'h8000_0000_0000_0000;
      end else begin
        mag = {11'b0, mant} << (effExp - UNITY_EXP);
      end
    end else begin
      rsh = 12'd1075 - {1'b0, effExp};
      if (rsh >= 12'(EXT_W)) begin
        sticky = |mant;
      end else begin
        shifted = {mant, 64'b0} >> rsh;
        intPart = shifted[EXT_W-1:64];
        guard   = shifted[63];
        sticky  = |shifted[62:0];
      end
      case (roundMode)
        RND_NEAR: roundUp = guard & (sticky | intPart[0]);
        RND_DOWN: roundUp = sgn & (guard | sticky);
        RND_UP:   roundUp = !sgn & (guard | sticky);
        default:  roundUp = 1'b0;
      endcase
      mag     = {11'b0, intPart} + {63'b0, roundUp};
      inexact = guard | sticky;
    end
    intOut = invalid ? 64'h8000_0000_0000_0000 : (sgn ? -mag : mag);
  end

  // R9: a NaN or infinity input must always raise invalid
  always_comb begin
    if (fpIn[62:52] == 11'h7FF) a_r9_nan_inf_invalid: assert (invalid && !inexact);
  end
endmodule

// File: rtl/dq_vec_ctrl.sv
module dq_vec_ctrl
  import dq_vec_pkg::*;
(
  input  logic                 inValid,
  input  logic [1:0]           vecLen,
  input  logic                 maskEn,
  input  logic [NUM_LANES-1:0] mask,
  input  logic                 zeroMode,
  input  logic                 bcastBit,
  input  logic                 srcIsMem,
  input  logic [1:0]           embRound,
  input  logic [1:0]           glbRound,
  input  logic [3:0]           regSpec,
  output laneStrobes_t         strobes
);
  localparam int LANES_128 = NUM_LANES / 4;
  localparam int LANES_256 = NUM_LANES / 2;

  logic [NUM_LANES-1:0] laneLimit;
  logic [NUM_LANES-1:0] enabled;
  logic                 fullWidth;
  logic                 undef;

  always_comb begin
    case (vecLen)
      2'd0:    laneLimit = NUM_LANES'((1 << LANES_128) - 1);
      2'd1:    laneLimit = NUM_LANES'((1 << LANES_256) - 1);
      default: laneLimit = '1;
    endcase
    fullWidth = vecLen[1];
    undef     = (regSpec != 4'hF);
    enabled   = maskEn ? mask : '1;

    strobes.capture   = inValid;
    strobes.undef     = undef;
    strobes.useBcast  = bcastBit & srcIsMem;
    strobes.roundMode = (fullWidth && !srcIsMem && bcastBit) ? roundMode_t'(embRound)
                                                             : roundMode_t'(glbRound);
    strobes.laneWrite = undef ? '0 : (laneLimit & enabled);
    strobes.laneZero  = undef ? '0 : (~laneLimit | (laneLimit & ~enabled & {NUM_LANES{zeroMode}}));
  end
endmodule

// File: rtl/dq_vec_datapath.sv
module dq_vec_datapath
  import dq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneStrobes_t     strobes,
  input  logic [VEC_W-1:0] prevDest,
  input  logic [VEC_W-1:0] srcVec,
  output logic             outValid,
  output logic [VEC_W-1:0] outDest,
  output logic             outInvalid,
  output logic             outInexact,
  output logic             outUndef
);
  logic [VEC_W-1:0]     nextDest;
  logic [NUM_LANES-1:0] laneInv;
  logic [NUM_LANES-1:0] laneInx;

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic [LANE_W-1:0] laneSrc;
    logic [LANE_W-1:0] laneConv;
    logic              convInv, convInx;

    assign laneSrc = strobes.useBcast ? srcVec[LANE_W-1:0] : srcVec[j*LANE_W +: LANE_W];

    dq_lane_convert conv_i (
      .fpIn      (laneSrc),
      .roundMode (strobes.roundMode),
      .intOut    (laneConv),
      .invalid   (convInv),
      .inexact   (convInx)
    );

    always_comb begin
      if (strobes.laneWrite[j])     nextDest[j*LANE_W +: LANE_W] = laneConv;
      else if (strobes.laneZero[j]) nextDest[j*LANE_W +: LANE_W] = '0;
      else                          nextDest[j*LANE_W +: LANE_W] = prevDest[j*LANE_W +: LANE_W];
    end

    assign laneInv[j] = convInv & strobes.laneWrite[j];
    assign laneInx[j] = convInx & strobes.laneWrite[j];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outDest    <= '0;
      outInvalid <= 1'b0;
      outInexact <= 1'b0;
      outUndef   <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outDest    <= nextDest;
        outInvalid <= |laneInv;
        outInexact <= |laneInx;
        outUndef   <= strobes.undef;
      end
    end
  end

  // R10: an operation that writes no lane reports no status
  a_r10_no_write_no_flags: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && strobes.laneWrite == '0 |=> !outInvalid && !outInexact);
endmodule

// File: rtl/dq_vec_convert.sv
module dq_vec_convert
  import dq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       vecLen,
  input  logic             maskEn,
  input  logic [7:0]       mask,
  input  logic             zeroMode,
  input  logic             bcastBit,
  input  logic             srcIsMem,
  input  logic [1:0]       embRound,
  input  logic [1:0]       glbRound,
  input  logic [3:0]       regSpec,
  input  logic [511:0]     prevDest,
  input  logic [511:0]     srcVec,
  output logic             outValid,
  output logic [511:0]     outDest,
  output logic             outInvalid,
  output logic             outInexact,
  output logic             outUndef
);
  laneStrobes_t strobes;

  dq_vec_ctrl ctrl_i (
    .inValid  (inValid),
    .vecLen   (vecLen),
    .maskEn   (maskEn),
    .mask     (mask),
    .zeroMode (zeroMode),
    .bcastBit (bcastBit),
    .srcIsMem (srcIsMem),
    .embRound (embRound),
    .glbRound (glbRound),
    .regSpec  (regSpec),
    .strobes  (strobes)
  );

  dq_vec_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .prevDest   (prevDest),
    .srcVec     (srcVec),
    .outValid   (outValid),
    .outDest    (outDest),
    .outInvalid (outInvalid),
    .outInexact (outInexact),
    .outUndef   (outUndef)
  );

  a_r1_one_cycle_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_upper_clear_128: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regSpec == 4'hF && vecLen == 2'd0 |=> outDest[511:128] == '0);
  a_r4_merge_keeps: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regSpec == 4'hF && vecLen[1] && maskEn && !zeroMode && mask == 8'h00
    |=> outDest == $past(prevDest));
  a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regSpec == 4'hF && maskEn && zeroMode && mask == 8'h00
    |=> outDest == '0 && !outInvalid && !outInexact);
  a_r11_undef_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regSpec != 4'hF |=> outUndef && outDest == $past(prevDest) && !outInvalid);
endmodule

// File: tb/dq_vec_convert_tb_top.sv
`timescale 1ns/1ps
module dq_vec_convert_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic         inValid = 0;
  logic [1:0]   vecLen = 0;
  logic         maskEn = 0;
  logic [7:0]   mask = 0;
  logic         zeroMode = 0;
  logic         bcastBit = 0;
  logic         srcIsMem = 0;
  logic [1:0]   embRound = 0;
  logic [1:0]   glbRound = 0;
  logic [3:0]   regSpec = 4'hF;
  logic [511:0] prevDest = '0;
  logic [511:0] srcVec = '0;
  logic         outValid;
  logic [511:0] outDest;
  logic         outInvalid, outInexact, outUndef;

  dq_vec_convert dut_i (.*);

  typedef struct {
    logic [511:0] dest;
    logic         inv;
    logic         inx;
    logic         undef;
    string        tag;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Source value table: 2.5, -2.5, 1.5, -1.75, 0.25, NaN, 2^63, -2^63
  function automatic logic [63:0] srcBits(input logic [2:0] idx);
    case (idx)
      3'd0: return 64'h4004_0000_0000_0000;
      3'd1: return 64'hC004_0000_0000_0000;
      3'd2: return 64'h3FF8_0000_0000_0000;
      3'd3: return 64'hBFFC_0000_0000_0000;
      3'd4: return 64'h3FD0_0000_0000_0000;
      3'd5: return 64'h7FF8_0000_0000_0000;
      3'd6: return 64'h43E0_0000_0000_0000;
      default: return 64'hC3E0_0000_0000_0000;
    endcase
  endfunction

  // returns {invalid, inexact, value}; rounding 0 near-even, 1 down, 2 up, 3 zero
  function automatic logic [65:0] refConv(input logic [2:0] idx, input logic [1:0] rm);
    logic signed [63:0] v;
    case (idx)
      3'd0: begin v = (rm == 2'd2) ? 64'sd3 : 64'sd2; return {2'b01, v}; end
      3'd1: begin v = (rm == 2'd1) ? -64'sd3 : -64'sd2; return {2'b01, v}; end
      3'd2: begin v = (rm == 2'd0 || rm == 2'd2) ? 64'sd2 : 64'sd1; return {2'b01, v}; end
      3'd3: begin v = (rm == 2'd0 || rm == 2'd1) ? -64'sd2 : -64'sd1; return {2'b01, v}; end
      3'd4: begin v = (rm == 2'd2) ? 64'sd1 : 64'sd0; return {2'b01, v}; end
      3'd5, 3'd6: return {2'b10, 64'h8000_0000_0000_0000};
      default: return {2'b00, 64'h8000_0000_0000_0000};
    endcase
  endfunction

  function automatic logic [511:0] buildSrc(input logic [23:0] idxs);
    logic [511:0] s;
    for (int j = 0; j < 8; j++) s[j*64 +: 64] = srcBits(idxs[j*3 +: 3]);
    return s;
  endfunction

  task automatic check(input string tag, input string what, input logic [511:0] act, input logic [511:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic runOp(input logic [1:0] vl, input logic me, input logic [7:0] mk, input logic zm,
                       input logic bb, input logic mem, input logic [1:0] er, input logic [1:0] gr,
                       input logic [3:0] rs, input logic [23:0] idxs, input logic [511:0] prev,
                       input string tag);
    expItem_t e;
    int kl;
    logic [1:0] rm;
    kl = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    rm = (vl[1] && !mem && bb) ? er : gr;
    e.dest = '0; e.inv = 0; e.inx = 0; e.undef = (rs != 4'hF); e.tag = tag;
    if (e.undef) e.dest = prev;
    else begin
      for (int j = 0; j < 8; j++) begin
        logic [65:0] r;
        logic [2:0] ix;
        ix = (bb && mem) ? idxs[2:0] : idxs[j*3 +: 3];
        if (j >= kl) e.dest[j*64 +: 64] = '0;
        else if (!me || mk[j]) begin
          r = refConv(ix, rm);
          e.dest[j*64 +: 64] = r[63:0];
          e.inv |= r[65];
          e.inx |= r[64];
        end else e.dest[j*64 +: 64] = zm ? 64'd0 : prev[j*64 +: 64];
      end
    end
    @(negedge clk);
    vecLen = vl; maskEn = me; mask = mk; zeroMode = zm; bcastBit = bb; srcIsMem = mem;
    embRound = er; glbRound = gr; regSpec = rs; srcVec = buildSrc(idxs); prevDest = prev;
    inValid = 1'b1;
    sbQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected outValid actual=1 expected=0");
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        check(e.tag, "dest", outDest, e.dest);
        check(e.tag, "invalid(R10)", {511'b0, outInvalid}, {511'b0, e.inv});
        check(e.tag, "inexact(R10)", {511'b0, outInexact}, {511'b0, e.inx});
        check(e.tag, "undef(R11)", {511'b0, outUndef}, {511'b0, e.undef});
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [511:0] prevPat;
  logic [23:0]  allIdx;

  initial begin
    prevPat = {8{64'hA5A5_0000_5A5A_1111}};
    for (int j = 0; j < 8; j++) prevPat[j*64 +: 8] = 8'(j + 1);
    allIdx = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check("R12", "reset outValid", {511'b0, outValid}, '0);
    check("R12", "reset outDest", outDest, '0);
    check("R12", "reset flags", {509'b0, outInvalid, outInexact, outUndef}, '0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: no result without a strobe
    check("R1", "idle outValid", {511'b0, outValid}, '0);

    // R8 R9: all rounding modes on the full table, back to back
    runOp(2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hF, allIdx, prevPat, "R8_R9_near");
    runOp(2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd1, 4'hF, allIdx, prevPat, "R8_R9_down");
    runOp(2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd2, 4'hF, allIdx, prevPat, "R8_R9_up");
    runOp(2'd3, 0, 8'h00, 0, 0, 0, 2'd0, 2'd3, 4'hF, allIdx, prevPat, "R8_R9_zero");
    idle();
    // R3 R4 R2: 256-bit merge masking
    runOp(2'd1, 1, 8'b1111_0101, 0, 0, 0, 2'd0, 2'd0, 4'hF, allIdx, prevPat, "R3_R4_R2_merge256");
    idle();
    // R5 R2: 128-bit zero masking
    runOp(2'd0, 1, 8'b0000_0010, 1, 0, 0, 2'd0, 2'd2, 4'hF, allIdx, prevPat, "R5_R2_zero128");
    // R4: merge with every bit clear at 512
    runOp(2'd2, 1, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hF, allIdx, prevPat, "R4_merge_all");
    idle();
    // R6: broadcast from memory at 512, lane0 = 0.25
    runOp(2'd2, 0, 8'h00, 0, 1, 1, 2'd0, 2'd2, 4'hF, {3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7, 3'd4}, prevPat, "R6_bcast512");
    // R6 R7: broadcast at 256 with memory, embedded field ignored
    runOp(2'd1, 0, 8'h00, 0, 1, 1, 2'd2, 2'd3, 4'hF, {21'd0, 3'd0}, prevPat, "R6_R7_bcast256");
    // R7: register source at 512 with bit set: embedded used, no broadcast
    runOp(2'd2, 0, 8'h00, 0, 1, 0, 2'd2, 2'd3, 4'hF, allIdx, prevPat, "R7_embedded");
    // R7: register source at 256 with bit set: global used
    runOp(2'd1, 0, 8'h00, 0, 1, 0, 2'd2, 2'd3, 4'hF, allIdx, prevPat, "R7_global256");
    idle();
    // R10: NaN lanes masked off and above the length do not raise invalid
    runOp(2'd2, 1, 8'b1001_1111, 1, 0, 0, 2'd0, 2'd0, 4'hF, allIdx, prevPat, "R10_masked_nan");
    runOp(2'd0, 0, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hF, {3'd5, 3'd6, 3'd5, 3'd6, 3'd5, 3'd5, 3'd2, 3'd3}, prevPat, "R10_upper_nan");
    // R9: exact -2^63 only
    runOp(2'd0, 0, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hF, {18'd0, 3'd7, 3'd7}, prevPat, "R9_min_int");
    // R11: illegal specifier
    runOp(2'd2, 0, 8'h00, 1, 0, 0, 2'd0, 2'd0, 4'b0111, allIdx, prevPat, "R11_undef");
    idle();
    repeat (3) @(negedge clk);
    check("R1", "queue drained", {480'b0, 32'(sbQ.size())}, '0);
    check("R1", "valid low when idle", {511'b0, outValid}, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule